// File: doc/BRIEF.md
# Address-Sequence Command Detector

The detector watches completed access cycles on an asynchronous-SRAM-style memory bus and recognises a hidden command, encoded as six back-to-back read cycles to fixed addresses. Each cycle arrives as one strobe together with its sampled address and a read/write flag. A read counts whether the bus master clocked it with chip enable or with output enable. Output enable does not need to be active, so any completed read strobe qualifies. The detector produces no data and never stalls the bus: every strobe is taken in the cycle it is presented, and there is no back-pressure.

All four commands share a five-read prefix. The sixth read picks the command. When the sixth read matches, the block raises a one-cycle pulse with a command code. The read data of that sixth cycle is returned by the memory as usual, outside this block. Any write, and any read to an address the sequence does not expect, breaks the match. While the external busy/inhibit input is high, the matcher is held in its idle state, because the memory ignores accesses during a nonvolatile transfer. A progress output shows how many prefix reads have matched so far.

Top module: `seqcmd_detector`

## Requirements
- R1: Reads whose address keys equal 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, taken in that order, raise `progress` to 1, 2, 3, 4 and 5, one cycle after each strobe.
- R2: With `progress` at 5, a read matching a final address raises `cmd_valid` for exactly one cycle, the cycle after the strobe. `cmd_code` then holds the command: 0 = store (0x8FC0), 1 = recall (0x4C63), 2 = automatic-store off (0x8B45), 3 = automatic-store on (0x4B46). `progress` returns to 0 at the same time.
- R3: Only address bits 14 down to 2 are compared. Bits 1:0 and bits above 14 have no effect, and a difference in any of bits 14:2 counts as a mismatch.
- R4: A write strobe (`cyc_write`=1) sets `progress` to 0 and never issues a command, even when it targets the expected address.
- R5: A read that does not match the expected address sets `progress` to 0. If that read matches the first prefix address (0x4E38), `progress` becomes 1 instead.
- R6: While `busy` is 1, `progress` is forced to 0, no command is issued, and strobes are ignored.
- R7: During and after reset, `progress` is 0 and `cmd_valid` is 0. A reset in the middle of a sequence discards it.
- R8: Cycles with `cyc_valid`=0 leave `progress` unchanged and issue no command.
- R9: With `progress` at 5, a sixth read matching no final address issues no command (R5 then applies).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | One completed bus access cycle this clock |
| cyc_write | input | 1 | 1 = the cycle was a write, 0 = a read |
| cyc_addr | input | ADDR_W (19) | Sampled address of the cycle |
| busy | input | 1 | Transfer in progress; accesses are inhibited |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 2 | Decoded command, valid with `cmd_valid` |
| progress | output | 3 | Number of prefix reads matched (0..5) |

## Verification
Every result is registered once, so `progress`, `cmd_valid` and `cmd_code` reflect a strobe exactly one clock after the edge that samples it. The bench drives each cycle shortly after a falling edge and compares the outputs 1 ns after the next rising edge, before driving the following cycle. A pulse that lasts too long therefore shows up as a mismatch in the next vector. Idle and busy vectors are checked on the same one-cycle schedule, so a held or dropped state is seen in the cycle it should appear.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;
  localparam int PREFIX_LEN = 5;
  localparam int N_CMD      = 4;

  typedef enum logic [1:0] {
    CMD_STORE  = 2'd0,
    CMD_RECALL = 2'd1,
    CMD_AS_OFF = 2'd2,
    CMD_AS_ON  = 2'd3
  } cmd_e;

  // Ordered prefix shared by every command
  localparam logic [15:0] PREFIX_ADDR [PREFIX_LEN] =
    '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};

  // Final address per command, indexed by cmd_e value
  localparam logic [15:0] FINAL_ADDR [N_CMD] =
    '{16'h8FC0, 16'h4C63, 16'h8B45, 16'h4B46};
endpackage

// File: rtl/seqcmd_match.sv
module seqcmd_match
  import seqcmd_pkg::*;
#(
  parameter int KEY_LSB = 2,
  parameter int KEY_MSB = 14,
  localparam int KEY_W  = KEY_MSB - KEY_LSB + 1
) (
  input  logic [KEY_W-1:0]      key,
  output logic [PREFIX_LEN-1:0] pre_hit,
  output logic [N_CMD-1:0]      fin_hit
);
  // one comparator per pattern
  for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_pre
    assign pre_hit[i] = (key == PREFIX_ADDR[i][KEY_MSB:KEY_LSB]);
  end
  for (genvar j = 0; j < N_CMD; j++) begin : g_fin
    assign fin_hit[j] = (key == FINAL_ADDR[j][KEY_MSB:KEY_LSB]);
  end
endmodule

// File: rtl/seqcmd_fsm.sv
module seqcmd_fsm
  import seqcmd_pkg::*;
#(
  localparam int STEP_W = $clog2(PREFIX_LEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cyc_valid,
  input  logic                  cyc_write,
  input  logic                  busy,
  input  logic [PREFIX_LEN-1:0] pre_hit,
  input  logic [N_CMD-1:0]      fin_hit,
  output logic [STEP_W-1:0]     step,
  output logic                  cmd_valid,
  output logic [1:0]            cmd_code
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX_LEN);

  logic       cur_hit;
  logic       any_fin;
  logic [1:0] code_nxt;

  always_comb begin
    cur_hit = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++)
      if (step == STEP_W'(i)) cur_hit = pre_hit[i];
  end

  always_comb begin
    any_fin  = |fin_hit;
    code_nxt = 2'd0;
    for (int j = N_CMD - 1; j >= 0; j--)
      if (fin_hit[j]) code_nxt = 2'(j);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= '0;
      cmd_valid <= 1'b0;
      cmd_code  <= 2'd0;
    end else begin
      cmd_valid <= 1'b0;
      if (busy) begin
        step <= '0;
      end else if (cyc_valid) begin
        if (cyc_write) begin
          step <= '0;
        end else if (step == LAST && any_fin) begin
          cmd_valid <= 1'b1;
          cmd_code  <= code_nxt;
          step      <= '0;
        end else if (step != LAST && cur_hit) begin
          step <= step + 1'b1;
        end else if (pre_hit[0]) begin
          step <= STEP_W'(1);
        end else begin
          step <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/seqcmd_detector.sv
module seqcmd_detector
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int KEY_LSB = 2,
  parameter int KEY_MSB = 14,
  localparam int KEY_W  = KEY_MSB - KEY_LSB + 1,
  localparam int STEP_W = $clog2(PREFIX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              busy,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic [STEP_W-1:0] progress
);
  logic [KEY_W-1:0]      key;
  logic [PREFIX_LEN-1:0] pre_hit;
  logic [N_CMD-1:0]      fin_hit;
  logic                  unused_addr_bits;

  assign key = cyc_addr[KEY_MSB:KEY_LSB];
  assign unused_addr_bits = ^{cyc_addr[ADDR_W-1:KEY_MSB+1], cyc_addr[KEY_LSB-1:0]};

  seqcmd_match #(.KEY_LSB(KEY_LSB), .KEY_MSB(KEY_MSB)) u_match (
    .key     (key),
    .pre_hit (pre_hit),
    .fin_hit (fin_hit)
  );

  seqcmd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_valid (cyc_valid),
    .cyc_write (cyc_write),
    .busy      (busy),
    .pre_hit   (pre_hit),
    .fin_hit   (fin_hit),
    .step      (progress),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code)
  );
endmodule

// File: rtl/seqcmd_detector_chk.sv
module seqcmd_detector_chk
  import seqcmd_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_valid,
  input logic              cyc_write,
  input logic              busy,
  input logic              cmd_valid,
  input logic [STEP_W-1:0] progress
);
  // R1
  progress_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    progress <= STEP_W'(PREFIX_LEN));
  // R2
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R2
  cmd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(progress) == STEP_W'(PREFIX_LEN)) && $past(cyc_valid)
                  && !$past(cyc_write) && !$past(busy) && (progress == '0));
  // R4
  write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_write) |=> (progress == '0) && !cmd_valid);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (progress == '0) && !cmd_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_valid && !busy) |=> $stable(progress) && !cmd_valid);
endmodule

bind seqcmd_detector seqcmd_detector_chk #(.STEP_W(STEP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_valid (cyc_valid),
  .cyc_write (cyc_write),
  .busy      (busy),
  .cmd_valid (cmd_valid),
  .progress  (progress)
);

// File: tb/seqcmd_detector_tb.sv
module seqcmd_detector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic        cyc_write = 1'b0;
  logic [18:0] cyc_addr = '0;
  logic        busy = 1'b0;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  logic [2:0]  progress;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seqcmd_detector u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
    .cyc_addr(cyc_addr), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .progress(progress)
  );

  // [29:26] req, [25] valid, [24] write, [23] noise, [22] busy,
  // [21:6] addr, [5:3] progress, [2] cmd_valid, [1:0] code
  function automatic logic [29:0] mk(int rq, bit v, bit w, bit nz, bit b,
                                     logic [15:0] a, int p, bit cv, int cd);
    return {4'(rq), v, w, nz, b, a, 3'(p), cv, 2'(cd)};
  endfunction

  function automatic string rname(int rq);
    case (rq)
      1: return "R1";  2: return "R2";  3: return "R3";
      4: return "R4";  5: return "R5";  6: return "R6";
      7: return "R7";  8: return "R8";  default: return "R9";
    endcase
  endfunction

  localparam int N = 63;
  localparam logic [29:0] VEC [N] = '{
    // store
    mk(1,1,0,0,0,16'h4E38,1,0,0), mk(1,1,0,0,0,16'hB1C7,2,0,0),
    mk(1,1,0,0,0,16'h83E0,3,0,0), mk(1,1,0,0,0,16'h7C1F,4,0,0),
    mk(1,1,0,0,0,16'h703F,5,0,0), mk(2,1,0,0,0,16'h8FC0,0,1,0),
    mk(8,0,0,0,0,16'h0000,0,0,0),
    // recall, with the ignored address bits toggled
    mk(3,1,0,1,0,16'h4E38,1,0,0), mk(3,1,0,1,0,16'hB1C7,2,0,0),
    mk(3,1,0,1,0,16'h83E0,3,0,0), mk(3,1,0,1,0,16'h7C1F,4,0,0),
    mk(3,1,0,1,0,16'h703F,5,0,0), mk(3,1,0,1,0,16'h4C63,0,1,1),
    // automatic-store off, with an idle gap
    mk(1,1,0,0,0,16'h4E38,1,0,0), mk(8,0,0,0,0,16'hFFFF,1,0,0),
    mk(1,1,0,0,0,16'hB1C7,2,0,0), mk(1,1,0,0,0,16'h83E0,3,0,0),
    mk(1,1,0,0,0,16'h7C1F,4,0,0), mk(1,1,0,0,0,16'h703F,5,0,0),
    mk(2,1,0,0,0,16'h8B45,0,1,2),
    // automatic-store on
    mk(1,1,0,0,0,16'h4E38,1,0,0), mk(1,1,0,0,0,16'hB1C7,2,0,0),
    mk(1,1,0,0,0,16'h83E0,3,0,0), mk(1,1,0,0,0,16'h7C1F,4,0,0),
    mk(1,1,0,0,0,16'h703F,5,0,0), mk(2,1,0,0,0,16'h4B46,0,1,3),
    // write abort
    mk(1,1,0,0,0,16'h4E38,1,0,0), mk(1,1,0,0,0,16'hB1C7,2,0,0),
    mk(4,1,1,0,0,16'h83E0,0,0,0), mk(4,1,0,0,0,16'h83E0,0,0,0),
    // mismatching read restarts on the first address
    mk(1,1,0,0,0,16'h4E38,1,0,0), mk(1,1,0,0,0,16'hB1C7,2,0,0),
    mk(5,1,0,0,0,16'h4E38,1,0,0), mk(5,1,0,0,0,16'hB1C7,2,0,0),
    mk(5,1,0,0,0,16'h83E0,3,0,0), mk(5,1,0,0,0,16'h1234,0,0,0),
    mk(3,1,0,0,0,16'h4E30,0,0,0),
    // bad sixth reads
    mk(1,1,0,0,0,16'h4E38,1,0,0), mk(1,1,0,0,0,16'hB1C7,2,0,0),
    mk(1,1,0,0,0,16'h83E0,3,0,0), mk(1,1,0,0,0,16'h7C1F,4,0,0),
    mk(1,1,0,0,0,16'h703F,5,0,0), mk(9,1,0,0,0,16'h4E38,1,0,0),
    mk(9,1,0,0,0,16'hB1C7,2,0,0), mk(9,1,0,0,0,16'h83E0,3,0,0),
    mk(9,1,0,0,0,16'h7C1F,4,0,0), mk(9,1,0,0,0,16'h703F,5,0,0),
    mk(9,1,0,0,0,16'h0000,0,0,0),
    // write to the final address
    mk(1,1,0,0,0,16'h4E38,1,0,0), mk(1,1,0,0,0,16'hB1C7,2,0,0),
    mk(1,1,0,0,0,16'h83E0,3,0,0), mk(1,1,0,0,0,16'h7C1F,4,0,0),
    mk(1,1,0,0,0,16'h703F,5,0,0), mk(4,1,1,0,0,16'h8FC0,0,0,0),
    // busy
    mk(1,1,0,0,0,16'h4E38,1,0,0), mk(6,1,0,0,1,16'hB1C7,0,0,0),
    mk(6,1,0,0,0,16'hB1C7,0,0,0),
    // still alive afterwards
    mk(1,1,0,0,0,16'h4E38,1,0,0), mk(1,1,0,0,0,16'hB1C7,2,0,0),
    mk(1,1,0,0,0,16'h83E0,3,0,0), mk(1,1,0,0,0,16'h7C1F,4,0,0),
    mk(1,1,0,0,0,16'h703F,5,0,0), mk(2,1,0,0,0,16'h8FC0,0,1,0)
  };

  task automatic chk(string rq, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, got, exp);
    end
  endtask

  // drive one cycle after a falling edge, sample 1 ns past the next rising edge
  task automatic cyc(bit v, bit w, logic [18:0] a, bit b);
    @(negedge clk);
    cyc_valid = v; cyc_write = w; cyc_addr = a; busy = b;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string rq, int p, bit cv, int cd);
    chk(rq, "progress", int'(progress), p);
    chk(rq, "cmd_valid", int'(cmd_valid), int'(cv));
    if (cv) chk(rq, "cmd_code", int'(cmd_code), cd);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state
    expect_out("R7", 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      logic [29:0] e;
      logic [18:0] a;
      e = VEC[i];
      a = {3'b000, e[21:6]};
      if (e[23]) a = {3'b101, e[21:6] ^ 16'h8003};
      cyc(e[25], e[24], a, e[22]);
      expect_out(rname(int'(e[29:26])), int'(e[5:3]), e[2], int'(e[1:0]));
    end

    // R7: reset in the middle of a sequence discards it
    cyc(1, 0, 19'h04E38, 0);
    cyc(1, 0, 19'h0B1C7, 0);
    @(negedge clk);
    cyc_valid = 1'b0; rst_n = 1'b0;
    @(posedge clk); #1;
    expect_out("R7", 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, 19'h083E0, 0);
    expect_out("R7", 0, 0, 0);

    // R6: busy at step 5 swallows the final read
    cyc(1, 0, 19'h04E38, 0);
    cyc(1, 0, 19'h0B1C7, 0);
    cyc(1, 0, 19'h083E0, 0);
    cyc(1, 0, 19'h07C1F, 0);
    cyc(1, 0, 19'h0703F, 0);
    expect_out("R6", 5, 0, 0);
    cyc(1, 0, 19'h08FC0, 1);
    expect_out("R6", 0, 0, 0);
    cyc(0, 0, 19'h0, 0);
    expect_out("R6", 0, 0, 0);

    // R2: the code is held after the pulse ends, the pulse does not repeat
    cyc(1, 0, 19'h04E38, 0);
    cyc(1, 0, 19'h0B1C7, 0);
    cyc(1, 0, 19'h083E0, 0);
    cyc(1, 0, 19'h07C1F, 0);
    cyc(1, 0, 19'h0703F, 0);
    cyc(1, 0, 19'h04C63, 0);
    expect_out("R2", 0, 1, 1);
    cyc(1, 0, 19'h04C63, 0);
    expect_out("R2", 0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule